// File: doc/BRIEF.md
# Operand Address Decoder

This block turns the operand-addressing bytes of a variable-length instruction into an operand description and a memory address. It takes the addressing byte, an optional scaled-index byte, the raw displacement bytes, three register-extension bits and the current address-size mode. From these it decides whether the operand is a register or a memory location, and which optional bytes the fetch stage still has to supply. For a memory operand it also computes the address from a base register, a scaled index register and a sign-extended displacement.

The decoder has two read ports into a register file with asynchronous read. During the cycle in which `start` is high, it presents the base register number on port A and the index register number on port B, and it expects the register values back in the same cycle. All results are captured at the next rising clock edge. They then stay unchanged until the next `start`.

Segment bases, instruction-pointer-relative forms and fault checks are not part of this block. With MOD=00 and R/M=101 in 32/64-bit mode, the block treats the displacement as an absolute address.

Top module: `ea_gen`

## Requirements
- R1: Register form. When modrm[7:6]=11, the result has is_mem=0, need_sib=0, disp_bytes=0 and ea=0. In this case rm_idx is the register operand.
- R2: Register numbers. reg_idx is always {rex_r, modrm[5:3]}, and rm_idx is always {rex_b, modrm[2:0]}.
- R3: Timing. valid is high for exactly one cycle, in the cycle after the `start` cycle. Without `start`, all other outputs keep their values.
- R4: Address-size codes are 00 for 16-bit, 01 for 32-bit, and 10 or 11 for 64-bit. In 32/64-bit mode, a memory form with modrm[2:0]=100 sets need_sib. The address is then base + (index << sib[7:6]) + displacement, with base register {rex_b, sib[2:0]} and index register {rex_x, sib[5:3]}.
- R5: Index field. In 32/64-bit mode, sib[5:3]=100 with rex_x=0 adds no index. With rex_x=1, register 12 is used as the index.
- R6: Base field. In 32/64-bit mode, with modrm[7:6]=00 and sib[2:0]=100b+1 (101), no base is added and a 4-byte displacement is used.
- R7: Direct form. In 32/64-bit mode, modrm[7:6]=00 with modrm[2:0]=101 uses no register, needs no scaled-index byte, and uses a 4-byte displacement.
- R8: Displacement size in 32/64-bit mode. MOD=01 takes disp_raw[7:0] (disp_bytes=1) and MOD=10 takes disp_raw[31:0] (disp_bytes=4). Both are sign-extended.
- R9: 16-bit register pairs, by modrm[2:0] with MOD≠11. Register numbers are BX=3, BP=5, SI=6, DI=7. The pairs are: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX. rex_x and rex_b do not affect the address.
- R10: 16-bit displacement size. MOD=01 gives 1 byte and MOD=10 gives 2 bytes, both sign-extended. MOD=00 with modrm[2:0]=110 is a bare 2-byte address with no register.
- R11: The sum is truncated to 16 bits in 16-bit mode and to 32 bits in 32-bit mode. The upper bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Decode strobe; inputs valid this cycle |
| modrm | input | 8 | Addressing byte |
| sib | input | 8 | Scaled-index byte (used only when needed) |
| disp_raw | input | 32 | Displacement bytes, little end in bits 7:0 |
| rex_r | input | 1 | Extension bit for the register field |
| rex_x | input | 1 | Extension bit for the index field |
| rex_b | input | 1 | Extension bit for the base / R/M field |
| asize | input | 2 | Address size: 00=16, 01=32, 1x=64 |
| rf_addr_a | output | 4 | Base register number to the register file |
| rf_data_a | input | XLEN | Base register value |
| rf_addr_b | output | 4 | Index register number to the register file |
| rf_data_b | input | XLEN | Index register value |
| valid | output | 1 | Result captured from last start |
| is_mem | output | 1 | Operand is in memory |
| need_sib | output | 1 | A scaled-index byte must be fetched |
| disp_bytes | output | 3 | Displacement length: 0, 1, 2 or 4 |
| reg_idx | output | 4 | Extended register-field number |
| rm_idx | output | 4 | Extended R/M register number |
| ea | output | XLEN | Truncated effective address |

## Verification
The properties assume that `start` samples a complete and consistent set of inputs. They also assume that the register file returns data in the same cycle as the address, so the captured address reflects the registers at the `start` edge. The bench keeps to these assumptions: it drives every input together with a one-cycle `start` away from the clock edge, and its register model answers combinationally from an array that changes only while the block is idle. Among the cases exercised are negative displacements, a 16-bit sum that wraps, and extension bits that are set where they must be ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;
   localparam int RIDX_W = 4;

   typedef enum logic [1:0] {
      ASZ16  = 2'b00,
      ASZ32  = 2'b01,
      ASZ64  = 2'b10,
      ASZ64B = 2'b11
   } asize_e;

   localparam logic [RIDX_W-1:0] GPR_BX = 4'd3;
   localparam logic [RIDX_W-1:0] GPR_BP = 4'd5;
   localparam logic [RIDX_W-1:0] GPR_SI = 4'd6;
   localparam logic [RIDX_W-1:0] GPR_DI = 4'd7;

   typedef struct packed {
      logic              is_mem;
      logic              need_sib;
      logic              use_base;
      logic              use_index;
      logic [1:0]        scale;
      logic [2:0]        disp_bytes;
      logic [RIDX_W-1:0] base_idx;
      logic [RIDX_W-1:0] index_idx;
      logic [RIDX_W-1:0] reg_idx;
      logic [RIDX_W-1:0] rm_idx;
   } ea_dec_t;
endpackage

// File: rtl/ea_dec16.sv
module ea_dec16 import ea_pkg::*; (
   input  logic [7:0] modrm,
   input  logic       rex_r,
   input  logic       rex_b,
   output ea_dec_t    dec
);
   logic [1:0] md;
   logic [2:0] rm;
   assign md = modrm[7:6];
   assign rm = modrm[2:0];

   always_comb begin
      dec            = '0;
      dec.reg_idx    = {rex_r, modrm[5:3]};
      dec.rm_idx     = {rex_b, rm};
      dec.is_mem     = (md != 2'b11);
      if (dec.is_mem) begin
         dec.use_base = 1'b1;
         unique case (rm)
            3'b000: begin dec.base_idx = GPR_BX; dec.index_idx = GPR_SI; dec.use_index = 1'b1; end
            3'b001: begin dec.base_idx = GPR_BX; dec.index_idx = GPR_DI; dec.use_index = 1'b1; end
            3'b010: begin dec.base_idx = GPR_BP; dec.index_idx = GPR_SI; dec.use_index = 1'b1; end
            3'b011: begin dec.base_idx = GPR_BP; dec.index_idx = GPR_DI; dec.use_index = 1'b1; end
            3'b100: dec.base_idx = GPR_SI;
            3'b101: dec.base_idx = GPR_DI;
            3'b110: begin
               dec.base_idx = GPR_BP;
               dec.use_base = (md != 2'b00);
            end
            default: dec.base_idx = GPR_BX;
         endcase
         unique case (md)
            2'b01:   dec.disp_bytes = 3'd1;
            2'b10:   dec.disp_bytes = 3'd2;
            default: dec.disp_bytes = (rm == 3'b110) ? 3'd2 : 3'd0;
         endcase
      end
   end
endmodule

// File: rtl/ea_dec32.sv
module ea_dec32 import ea_pkg::*; (
   input  logic [7:0] modrm,
   input  logic [7:0] sib,
   input  logic       rex_r,
   input  logic       rex_x,
   input  logic       rex_b,
   output ea_dec_t    dec
);
   logic [1:0] md;
   logic [2:0] rm;
   logic       sib_form;
   assign md       = modrm[7:6];
   assign rm       = modrm[2:0];
   assign sib_form = (md != 2'b11) && (rm == 3'b100);

   always_comb begin
      dec          = '0;
      dec.reg_idx  = {rex_r, modrm[5:3]};
      dec.rm_idx   = {rex_b, rm};
      dec.is_mem   = (md != 2'b11);
      if (dec.is_mem) begin
         unique case (md)
            2'b01:   dec.disp_bytes = 3'd1;
            2'b10:   dec.disp_bytes = 3'd4;
            default: dec.disp_bytes = 3'd0;
         endcase
         if (sib_form) begin
            dec.need_sib  = 1'b1;
            dec.scale     = sib[7:6];
            dec.index_idx = {rex_x, sib[5:3]};
            dec.use_index = !((sib[5:3] == 3'b100) && !rex_x);
            dec.base_idx  = {rex_b, sib[2:0]};
            if ((sib[2:0] == 3'b101) && (md == 2'b00)) begin
               dec.use_base   = 1'b0;
               dec.disp_bytes = 3'd4;
            end else begin
               dec.use_base   = 1'b1;
            end
         end else if ((rm == 3'b101) && (md == 2'b00)) begin
            dec.disp_bytes = 3'd4;
         end else begin
            dec.use_base = 1'b1;
            dec.base_idx = {rex_b, rm};
         end
      end
   end
endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
   parameter int XLEN   = 64,
   parameter int DISP_W = 32
) (
   input  logic [DISP_W-1:0] disp_raw,
   input  logic [2:0]        nbytes,
   output logic [XLEN-1:0]   disp_ext
);
   logic signed [XLEN-1:0] s8, s16, s32;

   always_comb begin
      s8  = $signed(disp_raw[7:0]);
      s16 = $signed(disp_raw[15:0]);
      s32 = $signed(disp_raw[31:0]);
      unique case (nbytes)
         3'd1:    disp_ext = s8;
         3'd2:    disp_ext = s16;
         3'd4:    disp_ext = s32;
         default: disp_ext = '0;
      endcase
   end
endmodule

// File: rtl/ea_agen_sum.sv
module ea_agen_sum import ea_pkg::*; #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] base_val,
   input  logic [XLEN-1:0] index_val,
   input  logic            use_base,
   input  logic            use_index,
   input  logic [1:0]      scale,
   input  logic [XLEN-1:0] disp_ext,
   input  asize_e          asz,
   output logic [XLEN-1:0] ea
);
   logic [XLEN-1:0] b_term, i_term, raw;

   always_comb begin
      b_term = use_base ? base_val : '0;
      i_term = (use_index ? index_val : '0) << scale;
      raw    = b_term + i_term + disp_ext;
   end

   generate
      if (XLEN == 64) begin : g_trunc64
         always_comb begin
            unique case (asz)
               ASZ16:   ea = {48'b0, raw[15:0]};
               ASZ32:   ea = {32'b0, raw[31:0]};
               default: ea = raw;
            endcase
         end
      end else begin : g_trunc32
         always_comb begin
            if (asz == ASZ16) ea = {16'b0, raw[15:0]};
            else              ea = raw;
         end
      end
   endgenerate
endmodule

// File: rtl/ea_gen.sv
module ea_gen import ea_pkg::*; #(
   parameter int XLEN   = 64,
   parameter int DISP_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        modrm,
   input  logic [7:0]        sib,
   input  logic [DISP_W-1:0] disp_raw,
   input  logic              rex_r,
   input  logic              rex_x,
   input  logic              rex_b,
   input  logic [1:0]        asize,
   output logic [3:0]        rf_addr_a,
   input  logic [XLEN-1:0]   rf_data_a,
   output logic [3:0]        rf_addr_b,
   input  logic [XLEN-1:0]   rf_data_b,
   output logic              valid,
   output logic              is_mem,
   output logic              need_sib,
   output logic [2:0]        disp_bytes,
   output logic [3:0]        reg_idx,
   output logic [3:0]        rm_idx,
   output logic [XLEN-1:0]   ea
);
   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("ea_gen: XLEN must be 32 or 64");
      end
      if (DISP_W != 32) begin : g_bad_disp
         $error("ea_gen: DISP_W must be 32");
      end
   endgenerate

   asize_e  asz;
   ea_dec_t dec16, dec32, dec;
   logic [XLEN-1:0] disp_ext, ea_nxt;

   assign asz = asize_e'(asize);

   ea_dec16 i_dec16 (
      .modrm (modrm),
      .rex_r (rex_r),
      .rex_b (rex_b),
      .dec   (dec16)
   );

   ea_dec32 i_dec32 (
      .modrm (modrm),
      .sib   (sib),
      .rex_r (rex_r),
      .rex_x (rex_x),
      .rex_b (rex_b),
      .dec   (dec32)
   );

   assign dec       = (asz == ASZ16) ? dec16 : dec32;
   assign rf_addr_a = dec.base_idx;
   assign rf_addr_b = dec.index_idx;

   ea_disp_ext #(.XLEN(XLEN), .DISP_W(DISP_W)) i_disp (
      .disp_raw (disp_raw),
      .nbytes   (dec.disp_bytes),
      .disp_ext (disp_ext)
   );

   ea_agen_sum #(.XLEN(XLEN)) i_sum (
      .base_val  (rf_data_a),
      .index_val (rf_data_b),
      .use_base  (dec.use_base),
      .use_index (dec.use_index),
      .scale     (dec.scale),
      .disp_ext  (disp_ext),
      .asz       (asz),
      .ea        (ea_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid      <= 1'b0;
         is_mem     <= 1'b0;
         need_sib   <= 1'b0;
         disp_bytes <= '0;
         reg_idx    <= '0;
         rm_idx     <= '0;
         ea         <= '0;
      end else begin
         valid <= start;
         if (start) begin
            is_mem     <= dec.is_mem;
            need_sib   <= dec.need_sib;
            disp_bytes <= dec.disp_bytes;
            reg_idx    <= dec.reg_idx;
            rm_idx     <= dec.rm_idx;
            ea         <= ea_nxt;
         end
      end
   end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [7:0]      modrm,
   input logic            rex_r,
   input logic            rex_b,
   input logic [1:0]      asize,
   input logic            valid,
   input logic            is_mem,
   input logic            need_sib,
   input logic [2:0]      disp_bytes,
   input logic [3:0]      reg_idx,
   input logic [3:0]      rm_idx,
   input logic [XLEN-1:0] ea
);
   // R1
   reg_form_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !is_mem) |-> (!need_sib && disp_bytes == 3'd0 && ea == '0));

   // R2
   reg_numbers_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (reg_idx == {$past(rex_r), $past(modrm[5:3])}
                 && rm_idx == {$past(rex_b), $past(modrm[2:0])}));

   // R3
   valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid);

   // R3
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !valid);

   // R3
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(ea) && $stable(reg_idx) && $stable(disp_bytes)));

   // R4
   sib_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && asize != 2'b00 && modrm[7:6] != 2'b11 && modrm[2:0] == 3'b100)
      |=> need_sib);

   // R8
   short_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && asize != 2'b00 && modrm[7:6] == 2'b01) |=> (disp_bytes == 3'd1));

   // R10
   disp16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && asize == 2'b00 && modrm[7:6] == 2'b10) |=> (disp_bytes == 3'd2));

   // R11
   trunc16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && asize == 2'b00) |=> (ea[XLEN-1:16] == '0));
endmodule

bind ea_gen ea_gen_chk #(.XLEN(XLEN)) i_ea_gen_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .modrm      (modrm),
   .rex_r      (rex_r),
   .rex_b      (rex_b),
   .asize      (asize),
   .valid      (valid),
   .is_mem     (is_mem),
   .need_sib   (need_sib),
   .disp_bytes (disp_bytes),
   .reg_idx    (reg_idx),
   .rm_idx     (rm_idx),
   .ea         (ea)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  modrm = '0, sib = '0;
   logic [31:0] disp_raw = '0;
   logic        rex_r = 1'b0, rex_x = 1'b0, rex_b = 1'b0;
   logic [1:0]  asize = 2'b01;
   logic [3:0]  rf_addr_a, rf_addr_b;
   logic [63:0] rf_data_a, rf_data_b;
   logic        valid, is_mem, need_sib;
   logic [2:0]  disp_bytes;
   logic [3:0]  reg_idx, rm_idx;
   logic [63:0] ea;

   logic [63:0] regs [16];
   int total = 0, bad = 0;

   logic [63:0] e_ea;
   logic        e_mem, e_sib;
   logic [2:0]  e_db;
   logic [3:0]  e_reg, e_rm;

   always #2.5 clk = ~clk;

   assign rf_data_a = regs[rf_addr_a];
   assign rf_data_b = regs[rf_addr_b];

   ea_gen i_ea_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .modrm(modrm), .sib(sib),
      .disp_raw(disp_raw), .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b),
      .asize(asize), .rf_addr_a(rf_addr_a), .rf_data_a(rf_data_a),
      .rf_addr_b(rf_addr_b), .rf_data_b(rf_data_b), .valid(valid),
      .is_mem(is_mem), .need_sib(need_sib), .disp_bytes(disp_bytes),
      .reg_idx(reg_idx), .rm_idx(rm_idx), .ea(ea)
   );

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL R3 watchdog: got=running exp=finished");
      summary();
   end

   task automatic model(input logic [7:0] m, input logic [7:0] s, input logic [31:0] d,
                        input logic r, input logic x, input logic b, input logic [1:0] az);
      int md, rm, nd, sh;
      logic [63:0] acc;
      logic signed [63:0] dv;
      md = int'(m[7:6]); rm = int'(m[2:0]);
      acc = 64'd0; nd = 0;
      e_reg = {r, m[5:3]}; e_rm = {b, m[2:0]};
      e_mem = (md != 3); e_sib = 1'b0;
      if (e_mem) begin
         if (az == 2'b00) begin
            nd = (md == 1) ? 1 : (md == 2) ? 2 : 0;
            case (rm)
               0: acc = regs[3] + regs[6];
               1: acc = regs[3] + regs[7];
               2: acc = regs[5] + regs[6];
               3: acc = regs[5] + regs[7];
               4: acc = regs[6];
               5: acc = regs[7];
               6: if (md == 0) nd = 2; else acc = regs[5];
               default: acc = regs[3];
            endcase
         end else begin
            nd = (md == 1) ? 1 : (md == 2) ? 4 : 0;
            if (rm == 4) begin
               e_sib = 1'b1;
               sh = int'(s[7:6]);
               if (!(s[5:3] == 3'b100 && !x)) acc = acc + regs[{x, s[5:3]}] * (64'd1 << sh);
               if (s[2:0] == 3'b101 && md == 0) nd = 4;
               else acc = acc + regs[{b, s[2:0]}];
            end else if (rm == 5 && md == 0) begin
               nd = 4;
            end else begin
               acc = regs[{b, m[2:0]}];
            end
         end
         case (nd)
            1: dv = $signed(d[7:0]);
            2: dv = $signed(d[15:0]);
            4: dv = $signed(d[31:0]);
            default: dv = 64'sd0;
         endcase
         acc = acc + dv;
         if (az == 2'b00) acc = acc & 64'hFFFF;
         else if (az == 2'b01) acc = acc & 64'hFFFF_FFFF;
      end
      e_ea = acc; e_db = 3'(nd);
   endtask

   task automatic compare(input string tag, input logic exp_valid);
      logic [78:0] got, exp;
      got = {valid, is_mem, need_sib, disp_bytes, reg_idx, rm_idx, ea};
      exp = {exp_valid, e_mem, e_sib, e_db, e_reg, e_rm, e_ea};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic run(input string tag, input logic [7:0] m, input logic [7:0] s,
                      input logic [31:0] d, input logic r, input logic x,
                      input logic b, input logic [1:0] az);
      @(negedge clk);
      modrm = m; sib = s; disp_raw = d; rex_r = r; rex_x = x; rex_b = b; asize = az;
      start = 1'b1;
      model(m, s, d, r, x, b, az);
      @(negedge clk);
      start = 1'b0;
      modrm = ~m; sib = ~s; disp_raw = ~d; rex_r = ~r;
      compare(tag, 1'b1);
   endtask

   initial begin
      for (int i = 0; i < 16; i++)
         regs[i] = {4'h8, 28'(i), 32'h0000_1000 + 32'(i) * 32'h111};
      repeat (3) @(negedge clk);
      // R3: reset state
      e_mem = 0; e_sib = 0; e_db = 0; e_reg = 0; e_rm = 0; e_ea = 0;
      compare("R3 reset", 1'b0);
      rst_n = 1'b1;

      // R1 R2: register form with extensions
      run("R1 R2 reg form", 8'hD0, 8'h00, 32'h11, 1'b1, 1'b1, 1'b1, 2'b10);
      // R4: scaled index, 32-bit
      run("R4 ebx+ecx*4", 8'h04, 8'h8B, 32'h0, 1'b0, 1'b0, 1'b0, 2'b01);
      // R4: 64-bit with extended base
      run("R4 r10+rcx*1", 8'h04, 8'h0A, 32'h0, 1'b0, 1'b0, 1'b1, 2'b10);
      run("R4 r11*8+rbx disp8", 8'h44, 8'hDB, 32'h7F, 1'b1, 1'b1, 1'b0, 2'b10);
      // R5: no index vs r12
      run("R5 no index", 8'h04, 8'hE3, 32'h0, 1'b0, 1'b0, 1'b0, 2'b10);
      run("R5 r12 index", 8'h04, 8'h63, 32'h0, 1'b0, 1'b1, 1'b0, 2'b10);
      // R6: no base, disp32
      run("R6 no base", 8'h04, 8'h4D, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 2'b10);
      // R7: bare disp32, negative
      run("R7 direct", 8'h05, 8'hFF, 32'hFFFF_FFF0, 1'b0, 1'b1, 1'b1, 2'b10);
      // R8: negative disp8 and disp32
      run("R8 disp8 neg", 8'h43, 8'h00, 32'h1234_5680, 1'b0, 1'b0, 1'b0, 2'b10);
      run("R8 disp32", 8'h83, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 2'b11);
      // R11: 32-bit truncation of a 64-bit register
      run("R11 trunc32", 8'h83, 8'h00, 32'h7000_0000, 1'b0, 1'b0, 1'b1, 2'b01);
      // R3: hold while idle
      @(negedge clk);
      @(negedge clk);
      compare("R3 hold", 1'b0);
      // R9: all 16-bit pairs, extension bits set
      for (int k = 0; k < 8; k++)
         run("R9 pair", 8'h50 | 8'(k), 8'h00, 32'h3E, 1'b0, 1'b1, 1'b1, 2'b00);
      // R10: direct address and disp16
      run("R10 direct16", 8'h16, 8'h00, 32'hABCD_8000, 1'b0, 1'b0, 1'b0, 2'b00);
      run("R10 bp+0", 8'h76, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 2'b00);
      run("R10 disp16 neg", 8'h80, 8'h00, 32'h0000_FF80, 1'b0, 1'b0, 1'b0, 2'b00);
      // R11: 16-bit wrap
      @(negedge clk);
      regs[3] = 64'hABCD_0000_0000_FFF0;
      regs[6] = 64'h0000_0000_0000_0020;
      run("R11 wrap16", 8'h40, 8'h00, 32'h05, 1'b0, 1'b0, 1'b0, 2'b00);
      run("R1 reg form 16", 8'hC7, 8'h00, 32'h05, 1'b0, 1'b0, 1'b1, 2'b00);
      @(negedge clk);
      summary();
   end
endmodule